// File: doc/BRIEF.md
# Fault-Time Program Counter Tracker

This block follows, cycle by cycle, the program counter value that a CPU core with a 16-bit bus must push on the stack when a bus or address error aborts an instruction. That value is not a plain fetch-and-increment counter. When address calculation ends, it takes an offset that depends on the addressing mode and the operand size. When the instruction's second part begins, it is copied from the arithmetic unit's next-fetch address. Destination operand fetches leave it alone. Jump-type instructions load their target directly, with no increment first.

The core's sequencer drives one strobe per phase: instruction start, address calculation done, second part begins, destination fetch, and branch target load. With these it supplies the 6-bit mode field, the operand size, a read-before-write flag, the next-fetch address and the branch target. When the fault strobe arrives, the block latches the tracked value into a stacked-PC register and raises a one-cycle valid pulse. After that it ignores every phase strobe until the next instruction starts. The exception sequencer reads the stacked value when it builds the stack frame.

Top module: `fault_pc_tracker`

## Requirements
- R1: While no fault is taken, an instruction-start strobe loads the tracked PC from `base_pc` on the next edge and clears `illegal_mode`. It takes precedence over every other phase strobe in the same cycle.
- R2: On the address-done strobe with byte size (`op_size`=00) or word size (01), the tracked PC advances by 2 for mode field 100rrr. It advances by 0 for 000rrr, 001rrr, 010rrr, 011rrr, 101rrr, 110rrr, 111010 and 111011.
- R3: On the address-done strobe with long size (`op_size`=10 or 11), every mode with bits [5:3] below 111, 100rrr included, advances the tracked PC by 0. So do 111010 and 111011.
- R4: Mode 111000 advances the tracked PC by 2 and mode 111001 advances it by 4, for every operand size. The result wraps modulo 2^ADDR_W.
- R5: Mode 111100 advances the tracked PC by 2 for byte or word size and by 4 for long size.
- R6: Modes 111101, 111110 and 111111 advance the tracked PC by 0 and set `illegal_mode`. Any legal mode on a later address-done strobe clears the flag.
- R7: A second-part strobe with `rbw_flag` low loads the tracked PC from `next_fetch_addr` on the next edge.
- R8: A destination-fetch strobe on its own leaves the tracked PC unchanged.
- R9: A second-part strobe with `rbw_flag` high leaves the tracked PC at its address-calculation value.
- R10: A branch-load strobe loads `branch_target` into the tracked PC without any increment. Within an instruction the priority is branch-load, then second-part, then address-done.
- R11: A fault strobe during an instruction copies the tracked PC as it stood before that edge into `stack_pc`. It raises `stack_valid` for exactly one cycle.
- R12: After a taken fault, phase strobes and further faults have no effect until an instruction-start strobe arrives. Phase strobes, instruction start included, that share the cycle of a taken fault are discarded.
- R13: During and right after reset, `track_pc`, `stack_pc`, `stack_valid` and `illegal_mode` are all zero, and faults are not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_start | input | 1 | Instruction start strobe |
| base_pc | input | ADDR_W | Address of the word past the opcode word |
| ea_done | input | 1 | Address calculation done strobe |
| ea_mode | input | 6 | Mode field, {mode[2:0], reg[2:0]} |
| op_size | input | 2 | 00 byte, 01 word, 10/11 long |
| part2_start | input | 1 | Second part begins strobe |
| rbw_flag | input | 1 | Read-before-write instruction, sampled with part2_start |
| dst_fetch | input | 1 | Destination extension word fetch strobe |
| next_fetch_addr | input | ADDR_W | Arithmetic unit next-fetch address |
| branch_load | input | 1 | Jump or branch target load strobe |
| branch_target | input | ADDR_W | Absolute target address |
| fault | input | 1 | Bus or address error strobe |
| track_pc | output | ADDR_W | Current tracked value |
| stack_pc | output | ADDR_W | Value to push on the stack |
| stack_valid | output | 1 | One-cycle pulse when stack_pc is captured |
| illegal_mode | output | 1 | Last decoded mode was reserved |

## Verification
The two functions that can meet in one cycle are fault capture and a phase update of the tracked PC. The bench raises the fault strobe together with an address-done, second-part, branch-load or instruction-start strobe. It expects `stack_pc` to hold the value from before the edge and `track_pc` to stay frozen. A behavioural model built from the requirements predicts every output on every clock, and the bench compares the design against it. After the fault, further strobes are applied to show that the tracker stays idle until a new instruction starts.

// File: rtl/fpt_pkg.sv
package fpt_pkg;

   localparam int MODE_W = 6;
   localparam int OFS_W  = 3;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_WORD = 2'b01,
      SZ_LONG = 2'b10,
      SZ_LALT = 2'b11
   } op_size_e;

   typedef enum logic [2:0] {
      SEL_HOLD   = 3'd0,
      SEL_BASE   = 3'd1,
      SEL_EA     = 3'd2,
      SEL_NEXT   = 3'd3,
      SEL_BRANCH = 3'd4
   } pc_sel_e;

   localparam logic [2:0] GRP_PREDEC = 3'b100;
   localparam logic [2:0] GRP_EXT    = 3'b111;
   localparam logic [2:0] EXT_ABS_S  = 3'b000;
   localparam logic [2:0] EXT_ABS_L  = 3'b001;
   localparam logic [2:0] EXT_PCD    = 3'b010;
   localparam logic [2:0] EXT_PCX    = 3'b011;
   localparam logic [2:0] EXT_IMM    = 3'b100;

endpackage

// File: rtl/fpt_ea_offset.sv
module fpt_ea_offset
   import fpt_pkg::*;
#(
   parameter int OW = OFS_W
) (
   input  logic [MODE_W-1:0] mode,
   input  logic [1:0]        size,
   output logic [OW-1:0]     offset,
   output logic              reserved
);

   localparam int HALF = MODE_W / 2;

   logic [HALF-1:0] grp;
   logic [HALF-1:0] sub;
   logic            is_long;

   assign grp     = mode[MODE_W-1:HALF];
   assign sub     = mode[HALF-1:0];
   assign is_long = size[1];

   always_comb begin
      offset   = '0;
      reserved = 1'b0;
      if (grp == GRP_EXT) begin
         unique case (sub)
            EXT_ABS_S: offset = OW'(2);
            EXT_ABS_L: offset = OW'(4);
            EXT_PCD,
            EXT_PCX:   offset = '0;
            EXT_IMM:   offset = is_long ? OW'(4) : OW'(2);
            default:   reserved = 1'b1;
         endcase
      end else if (grp == GRP_PREDEC) begin
         offset = is_long ? '0 : OW'(2);
      end
   end

endmodule

// File: rtl/fpt_phase_ctrl.sv
module fpt_phase_ctrl
   import fpt_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    insn_start,
   input  logic    ea_done,
   input  logic    part2_start,
   input  logic    rbw_flag,
   input  logic    branch_load,
   input  logic    fault,
   output pc_sel_e sel,
   output logic    fault_take,
   output logic    active
);

   logic active_q;

   assign fault_take = fault & active_q;
   assign active     = active_q;

   always_comb begin
      sel = SEL_HOLD;
      if (fault_take) begin
         sel = SEL_HOLD;
      end else if (insn_start) begin
         sel = SEL_BASE;
      end else if (active_q) begin
         if (branch_load)
            sel = SEL_BRANCH;
         else if (part2_start)
            sel = rbw_flag ? SEL_HOLD : SEL_NEXT;
         else if (ea_done)
            sel = SEL_EA;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         active_q <= 1'b0;
      else if (fault_take)
         active_q <= 1'b0;
      else if (insn_start)
         active_q <= 1'b1;
   end

endmodule

// File: rtl/fpt_pc_reg.sv
module fpt_pc_reg
   import fpt_pkg::*;
#(
   parameter int AW = 24,
   parameter int OW = OFS_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  pc_sel_e       sel,
   input  logic          fault_take,
   input  logic [AW-1:0] base_pc,
   input  logic [AW-1:0] next_fetch_addr,
   input  logic [AW-1:0] branch_target,
   input  logic [OW-1:0] ea_offset,
   input  logic          ea_reserved,
   output logic [AW-1:0] track_pc,
   output logic [AW-1:0] stack_pc,
   output logic          stack_valid,
   output logic          illegal_mode
);

   logic [AW-1:0] track_d;

   always_comb begin
      unique case (sel)
         SEL_BASE:   track_d = base_pc;
         SEL_EA:     track_d = track_pc + AW'(ea_offset);
         SEL_NEXT:   track_d = next_fetch_addr;
         SEL_BRANCH: track_d = branch_target;
         default:    track_d = track_pc;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         track_pc     <= '0;
         stack_pc     <= '0;
         stack_valid  <= 1'b0;
         illegal_mode <= 1'b0;
      end else begin
         track_pc    <= track_d;
         stack_valid <= fault_take;
         if (fault_take)
            stack_pc <= track_pc;
         if (sel == SEL_BASE)
            illegal_mode <= 1'b0;
         else if (sel == SEL_EA)
            illegal_mode <= ea_reserved;
      end
   end

endmodule

// File: rtl/fault_pc_tracker.sv
module fault_pc_tracker
   import fpt_pkg::*;
#(
   parameter int ADDR_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              insn_start,
   input  logic [ADDR_W-1:0] base_pc,
   input  logic              ea_done,
   input  logic [5:0]        ea_mode,
   input  logic [1:0]        op_size,
   input  logic              part2_start,
   input  logic              rbw_flag,
   input  logic              dst_fetch,
   input  logic [ADDR_W-1:0] next_fetch_addr,
   input  logic              branch_load,
   input  logic [ADDR_W-1:0] branch_target,
   input  logic              fault,
   output logic [ADDR_W-1:0] track_pc,
   output logic [ADDR_W-1:0] stack_pc,
   output logic              stack_valid,
   output logic              illegal_mode
);

   localparam int OW = OFS_W;

   generate
      if (ADDR_W < 16 || ADDR_W > 32) begin : g_bad_width
         $error("fault_pc_tracker: ADDR_W must lie in 16..32");
      end
      if (MODE_W != 6) begin : g_bad_mode
         $error("fault_pc_tracker: mode field must be 6 bits");
      end
   endgenerate

   pc_sel_e         sel;
   logic            fault_take;
   logic            active;
   logic [OW-1:0]   ea_offset;
   logic            ea_reserved;
   logic            dst_unused;

   assign dst_unused = dst_fetch;

   fpt_ea_offset #(.OW(OW)) u_ofs (
      .mode     (ea_mode),
      .size     (op_size),
      .offset   (ea_offset),
      .reserved (ea_reserved)
   );

   fpt_phase_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .insn_start  (insn_start),
      .ea_done     (ea_done),
      .part2_start (part2_start),
      .rbw_flag    (rbw_flag),
      .branch_load (branch_load),
      .fault       (fault),
      .sel         (sel),
      .fault_take  (fault_take),
      .active      (active)
   );

   fpt_pc_reg #(.AW(ADDR_W), .OW(OW)) u_reg (
      .clk             (clk),
      .rst_n           (rst_n),
      .sel             (sel),
      .fault_take      (fault_take),
      .base_pc         (base_pc),
      .next_fetch_addr (next_fetch_addr),
      .branch_target   (branch_target),
      .ea_offset       (ea_offset),
      .ea_reserved     (ea_reserved),
      .track_pc        (track_pc),
      .stack_pc        (stack_pc),
      .stack_valid     (stack_valid),
      .illegal_mode    (illegal_mode)
   );

endmodule

// File: rtl/fpt_checker.sv
module fpt_checker #(
   parameter int ADDR_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              insn_start,
   input logic [ADDR_W-1:0] base_pc,
   input logic              ea_done,
   input logic [5:0]        ea_mode,
   input logic              part2_start,
   input logic              rbw_flag,
   input logic              dst_fetch,
   input logic [ADDR_W-1:0] next_fetch_addr,
   input logic              branch_load,
   input logic [ADDR_W-1:0] branch_target,
   input logic              fault,
   input logic              active,
   input logic [ADDR_W-1:0] track_pc,
   input logic [ADDR_W-1:0] stack_pc,
   input logic              stack_valid,
   input logic              illegal_mode
);

   AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      insn_start && !fault |=> track_pc == $past(base_pc)); // R1

   AST_RESERVED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      active && ea_done && ea_mode[5:3] == 3'b111 && ea_mode[2:0] > 3'b100
      && !insn_start && !part2_start && !branch_load && !fault
      |=> illegal_mode && $stable(track_pc)); // R6

   AST_PART2_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      active && part2_start && !rbw_flag && !branch_load && !insn_start && !fault
      |=> track_pc == $past(next_fetch_addr)); // R7

   AST_DST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      dst_fetch && !insn_start && !ea_done && !part2_start && !branch_load && !fault
      |=> $stable(track_pc)); // R8

   AST_RBW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      active && part2_start && rbw_flag && !branch_load && !insn_start
      |=> $stable(track_pc)); // R9

   AST_BRANCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      active && branch_load && !insn_start && !fault
      |=> track_pc == $past(branch_target)); // R10

   AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      active && fault |=> stack_valid && stack_pc == $past(track_pc)); // R11

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      stack_valid |=> !stack_valid); // R11

   AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !active && !insn_start |=> $stable(track_pc) && !stack_valid); // R12

   AST_FAULT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      active && fault |=> $stable(track_pc) && !active); // R12

endmodule

bind fault_pc_tracker fpt_checker #(.ADDR_W(ADDR_W)) u_fpt_checker (
   .clk             (clk),
   .rst_n           (rst_n),
   .insn_start      (insn_start),
   .base_pc         (base_pc),
   .ea_done         (ea_done),
   .ea_mode         (ea_mode),
   .part2_start     (part2_start),
   .rbw_flag        (rbw_flag),
   .dst_fetch       (dst_fetch),
   .next_fetch_addr (next_fetch_addr),
   .branch_load     (branch_load),
   .branch_target   (branch_target),
   .fault           (fault),
   .active          (active),
   .track_pc        (track_pc),
   .stack_pc        (stack_pc),
   .stack_valid     (stack_valid),
   .illegal_mode    (illegal_mode)
);

// File: tb/fault_pc_tracker_bench.sv
module fault_pc_tracker_bench;

   localparam int CLK_PERIOD = 10;
   localparam int AW         = 24;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          insn_start, ea_done, part2_start, rbw_flag;
   logic          dst_fetch, branch_load, fault;
   logic [5:0]    ea_mode;
   logic [1:0]    op_size;
   logic [AW-1:0] base_pc, next_fetch_addr, branch_target;
   logic [AW-1:0] track_pc, stack_pc;
   logic          stack_valid, illegal_mode;

   int    n_cmp  = 0;
   int    n_bad  = 0;
   string cur_req = "R13";
   bit    done   = 1'b0;

   logic [AW-1:0] m_track, m_stack;
   logic          m_valid, m_ill, m_active;

   always #(CLK_PERIOD/2) clk = ~clk;

   fault_pc_tracker #(.ADDR_W(AW)) u_fault_pc_tracker (
      .clk(clk), .rst_n(rst_n), .insn_start(insn_start), .base_pc(base_pc),
      .ea_done(ea_done), .ea_mode(ea_mode), .op_size(op_size),
      .part2_start(part2_start), .rbw_flag(rbw_flag), .dst_fetch(dst_fetch),
      .next_fetch_addr(next_fetch_addr), .branch_load(branch_load),
      .branch_target(branch_target), .fault(fault), .track_pc(track_pc),
      .stack_pc(stack_pc), .stack_valid(stack_valid), .illegal_mode(illegal_mode)
   );

   function automatic int exp_ofs(input logic [5:0] m, input logic [1:0] s);
      bit lng = (s >= 2);
      if (m >= 6'o40 && m <= 6'o47) return lng ? 0 : 2;   // predecrement
      if (m == 6'o70) return 2;
      if (m == 6'o71) return 4;
      if (m == 6'o74) return lng ? 4 : 2;
      return 0;
   endfunction

   function automatic string req_of(input logic [5:0] m, input logic [1:0] s);
      if (m >= 6'o75) return "R6";
      if (m == 6'o74) return "R5";
      if (m == 6'o70 || m == 6'o71) return "R4";
      return (s >= 2) ? "R3" : "R2";
   endfunction

   // behavioural reference, updated at each rising edge
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_track = '0; m_stack = '0; m_valid = 0; m_ill = 0; m_active = 0;
      end else begin
         m_valid = 0;
         if (fault && m_active) begin
            m_stack = m_track; m_valid = 1; m_active = 0;
         end else if (insn_start) begin
            m_track = base_pc; m_active = 1; m_ill = 0;
         end else if (m_active) begin
            if (branch_load) m_track = branch_target;
            else if (part2_start) begin
               if (!rbw_flag) m_track = next_fetch_addr;
            end else if (ea_done) begin
               m_track = m_track + AW'(exp_ofs(ea_mode, op_size));
               m_ill = (ea_mode >= 6'o75);
            end
         end
      end
   end

   task automatic cmp(input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      #2;
      if (!done) begin
         cmp("track_pc", track_pc, m_track);
         cmp("stack_pc", stack_pc, m_stack);
         cmp("stack_valid", AW'(stack_valid), AW'(m_valid));
         cmp("illegal_mode", AW'(illegal_mode), AW'(m_ill));
      end
   end

   task automatic idle();
      insn_start = 0; ea_done = 0; part2_start = 0; rbw_flag = 0;
      dst_fetch = 0; branch_load = 0; fault = 0;
   endtask

   task automatic cyc();
      @(negedge clk);
      idle();
   endtask

   initial begin
      idle();
      rst_n = 0; ea_mode = 0; op_size = 0;
      base_pc = 0; next_fetch_addr = 0; branch_target = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      fault = 1;                      // R13: no fault accepted right after reset
      cyc();
      cyc();

      // R2 R3 R4 R5 R6: every mode under every size, then fault to stack it
      for (int s = 0; s < 4; s++) begin
         for (int m = 0; m < 64; m++) begin
            cur_req = req_of(6'(m), 2'(s));
            insn_start = 1; base_pc = AW'(24'h001000 + m * 16 + s * 4096);
            cyc();
            ea_done = 1; ea_mode = 6'(m); op_size = 2'(s);
            cyc();
            fault = 1;
            cyc();
         end
      end

      // R4: wrap at top of address space
      cur_req = "R4";
      insn_start = 1; base_pc = 24'hFFFFFE; cyc();
      ea_done = 1; ea_mode = 6'o71; op_size = 2'b10; cyc();
      fault = 1; cyc();

      // R6 cleared by a legal mode
      cur_req = "R6";
      insn_start = 1; base_pc = 24'h002000; cyc();
      ea_done = 1; ea_mode = 6'o77; cyc();
      ea_done = 1; ea_mode = 6'o00; cyc();

      // R7 then R8: second part loads next-fetch, destination fetches hold it
      cur_req = "R7";
      insn_start = 1; base_pc = 24'h003000; cyc();
      ea_done = 1; ea_mode = 6'o50; op_size = 1; cyc();
      part2_start = 1; next_fetch_addr = 24'h003006; cyc();
      cur_req = "R8";
      for (int k = 0; k < 3; k++) begin
         dst_fetch = 1; next_fetch_addr = AW'(24'h003008 + 2 * k); cyc();
      end
      fault = 1; cyc();

      // R9: read-before-write keeps address-calculation value
      cur_req = "R9";
      insn_start = 1; base_pc = 24'h004000; cyc();
      ea_done = 1; ea_mode = 6'o71; op_size = 1; cyc();
      part2_start = 1; rbw_flag = 1; next_fetch_addr = 24'h004008; cyc();
      fault = 1; cyc();

      // R10: jump target, no increment; priority over second part and ea
      cur_req = "R10";
      insn_start = 1; base_pc = 24'h005000; cyc();
      branch_load = 1; branch_target = 24'h000201; cyc();
      fault = 1; cyc();
      insn_start = 1; base_pc = 24'h005100; cyc();
      branch_load = 1; part2_start = 1; ea_done = 1; ea_mode = 6'o71;
      branch_target = 24'h006000; next_fetch_addr = 24'h007000; cyc();
      cur_req = "R1";
      insn_start = 1; ea_done = 1; branch_load = 1; base_pc = 24'h005200; cyc();

      // R11 + R12 collisions: fault with each kind of phase strobe
      cur_req = "R11";
      fault = 1; ea_done = 1; ea_mode = 6'o74; op_size = 2; cyc();
      cur_req = "R12";
      ea_done = 1; part2_start = 1; branch_load = 1; fault = 1; cyc();
      dst_fetch = 1; cyc();
      insn_start = 1; base_pc = 24'h008000; cyc();
      part2_start = 1; next_fetch_addr = 24'h008abc; fault = 1; cyc();
      insn_start = 1; base_pc = 24'h009000; cyc();
      insn_start = 1; base_pc = 24'h00A000; fault = 1; cyc();
      branch_load = 1; branch_target = 24'h00B000; cyc();
      cyc();

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule